// File: doc/BRIEF.md
# Page Hamming ECC Engine

This block watches the data stream of a NAND page as it crosses a byte or halfword bus and builds a single-error-correct, double-error-detect Hamming code over the whole data area in one step. When a page is written, software reads back a 32-bit code made of a 16-bit parity half and a 16-bit inverted-parity half, then stores it in the spare area. When a page is read, the stored code words are streamed straight after the data. The engine folds them into its accumulators, which turns the accumulators into a syndrome, and classifies the result.

Software reads three status flags and, for a correctable data error, a packed location: the word index in bits 15:4 and the bit offset in bits 3:0. It then repairs the data itself. A small register port selects one of four page sizes and the bus width, and restarts the calculation. The restart lets software throw away words that were wrongly counted, such as address cycles.

Each page holds a data area of `BASE_BYTES << size` bytes followed by a spare area of one thirty-second of that. With the default `BASE_BYTES` of 512 the total page sizes are 528, 1056, 2112 and 4224 bytes.

Top module: `hecc_page_engine`

## Requirements
- R1: After a synchronous active-low reset, the mode (offset 1), status (offset 2), parity (offset 3) and inverted-parity (offset 4) registers all read as zero. Mode zero means size 0 and 8-bit words.
- R2: For every set data bit, the parity register (offset 3, bits 15:0) accumulates the XOR of the 16-bit value {word_index[11:0], bit_offset[3:0]}. The inverted-parity register (offset 4, bits 15:0) accumulates the XOR of the bitwise complement of that value. The first data word of a page starts the accumulation afresh.
- R3: Mode bits 1:0 select size s. The data area is (BASE_BYTES << s) bytes and the spare area is one thirty-second of the data area. Incoming words are counted, and after the last word of a page the next word is word 0 of a new page, with no software action.
- R4: Writing a 1 to bit 0 of the control register (offset 0) zeroes the parity, inverted parity and status, and restarts the page at word 0.
- R5: In read direction (`st_read`=1), the code words that directly follow the data are XORed into the accumulators. In byte mode the byte order is parity low, parity high, inverted low, inverted high. In halfword mode the order is parity, then inverted. The registers then hold the syndrome, and status bit 0 (error) is set for any nonzero syndrome.
- R6: If the parity syndrome XOR the inverted syndrome equals 16'hFFFF, the status reads 3'b001 and the parity register holds the location of the bad data bit.
- R7: If exactly one of the 32 syndrome bits is set, the status reads 3'b101 (bit 2 marks an error inside the code).
- R8: Any other nonzero syndrome sets the status to 3'b011 (bit 1 marks an uncorrectable error). A fully erased page, with all data and code bytes equal to 8'hFF, reports 3'b011 with the parity register at 16'hFFFF.
- R9: Mode bit 4 selects 16-bit words. The location then indexes halfwords and bit offsets 0 to 15. In 8-bit mode, bits 15:8 of the stream data are ignored.
- R10: The status changes at the clock edge that accepts the last code word. It keeps that value until the first word of the next page, a restart, or reset.
- R11: In write direction (`st_read`=0), words after the data area leave the parity and inverted parity unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| st_valid | input | 1 | One bus word transferred this cycle |
| st_read | input | 1 | 1 = page read from flash, 0 = page write |
| st_data | input | 16 | Bus word; only bits 7:0 in byte mode |

## Verification
The bench builds the engine with `BASE_BYTES` set to 128, which gives pages of 132, 264, 528 and 1056 bytes. All four size selections and both word widths therefore run in a few thousand cycles, along with back-to-back pages that cross a wrap. At size 0 in byte mode, the spare area is exactly as long as the code. The last code word is then the last word of the page, so the status update coincides with the page boundary and the next page can start on the following cycle.

// File: rtl/hecc_pkg.sv
// Shared types and helpers for the page Hamming ECC engine.
// Assumes a 16-bit packed location: 12-bit word index over 4-bit bit offset.
package hecc_pkg;

    localparam int LOC_W   = 16;
    localparam int WADDR_W = 12;
    localparam int BIT_W   = 4;
    localparam int BUS_W   = 16;
    localparam int CTRL_CLR_BIT = 0;
    localparam int MODE_WIDE_BIT = 4;

    typedef enum logic [2:0] {
        OFS_CTRL = 3'd0,
        OFS_MODE = 3'd1,
        OFS_STAT = 3'd2,
        OFS_PAR  = 3'd3,
        OFS_NPAR = 3'd4
    } reg_ofs_e;

    typedef enum logic [1:0] {
        PH_DATA,
        PH_CODE,
        PH_SPARE
    } phase_e;

    typedef struct packed {
        logic code_err;
        logic multi_err;
        logic any_err;
    } stat_t;

    // Sort a syndrome into no error, data error, code error or multiple error.
    function automatic stat_t classify(input logic [LOC_W-1:0] p, input logic [LOC_W-1:0] n);
        stat_t s;
        s = '0;
        if ({n, p} != '0) begin
            s.any_err = 1'b1;
            if ((p ^ n) != {LOC_W{1'b1}}) begin
                if ($countones({n, p}) == 1)
                    s.code_err = 1'b1;
                else
                    s.multi_err = 1'b1;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/hecc_cfg_regs.sv
// Register port: holds the mode, decodes the restart strobe and muxes
// the read data. Assumes register writes happen between pages.
module hecc_cfg_regs
    import hecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  stat_t             stat,
    input  logic [LOC_W-1:0]  par,
    input  logic [LOC_W-1:0]  npar,
    output logic [31:0]       reg_rdata,
    output logic [1:0]        size_sel,
    output logic              wide,
    output logic              clr
);

    logic [1:0] size_q;
    logic       wide_q;
    logic       unused_wdata;

    assign unused_wdata = ^{reg_wdata[31:5], reg_wdata[3:2]};

    // Restart strobe, acted on at the same clock edge
    assign clr = reg_we && (reg_addr == OFS_CTRL) && reg_wdata[CTRL_CLR_BIT];

    // Mode register: size select and word width
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= 2'd0;
            wide_q <= 1'b0;
        end else if (reg_we && (reg_addr == OFS_MODE)) begin
            size_q <= reg_wdata[1:0];
            wide_q <= reg_wdata[MODE_WIDE_BIT];
        end
    end

    assign size_sel = size_q;
    assign wide     = wide_q;

    // Read mux over all visible registers
    always_comb begin
        reg_rdata = 32'h0;
        case (reg_addr)
            OFS_MODE: reg_rdata = {27'h0, wide_q, 2'b00, size_q};
            OFS_STAT: reg_rdata = {29'h0, stat};
            OFS_PAR:  reg_rdata = {16'h0, par};
            OFS_NPAR: reg_rdata = {16'h0, npar};
            default:  reg_rdata = 32'h0;
        endcase
    end

endmodule

// File: rtl/hecc_page_seq.sv
// Page word counter: tracks the position inside a page and splits it into
// data, code and spare phases. Assumes BASE_BYTES is a multiple of 128, so
// the spare area always holds the four code bytes.
module hecc_page_seq
    import hecc_pkg::*;
#(
    parameter int BASE_BYTES = 512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [1:0]         size_sel,
    input  logic               wide,
    input  logic               st_valid,
    output logic [WADDR_W-1:0] word_addr,
    output phase_e             phase,
    output logic [1:0]         code_slot,
    output logic               first_word,
    output logic               code_last
);

    localparam int MAX_BYTES = BASE_BYTES * 8 + BASE_BYTES / 4;
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] data_words;
    logic [CNT_W-1:0] page_words;
    logic [CNT_W-1:0] code_words;
    logic [CNT_W-1:0] code_off;

    // Page geometry from size select and width
    always_comb begin
        data_words = CNT_W'(BASE_BYTES) << size_sel;
        if (wide)
            data_words = data_words >> 1;
        page_words = data_words + (data_words >> 5);
        code_words = wide ? CNT_W'(2) : CNT_W'(4);
    end

    // Phase decode of the current word position
    always_comb begin
        code_off = cnt_q - data_words;
        if (cnt_q < data_words)
            phase = PH_DATA;
        else if (cnt_q < data_words + code_words)
            phase = PH_CODE;
        else
            phase = PH_SPARE;
    end

    assign code_slot  = code_off[1:0];
    assign first_word = (cnt_q == '0);
    assign code_last  = (phase == PH_CODE) && (code_off == code_words - CNT_W'(1));
    assign word_addr  = WADDR_W'(cnt_q);

    // Word counter that wraps at the end of a page
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (st_valid)
            cnt_q <= (cnt_q == page_words - CNT_W'(1)) ? '0 : cnt_q + CNT_W'(1);
    end

endmodule

// File: rtl/hecc_parity_acc.sv
// Parity accumulators: folds each data word's {word,bit} contribution into
// the parity and inverted-parity halves, and XORs stored code words in on
// a read. Assumes data_en and code_en are never high together.
module hecc_parity_acc
    import hecc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wide,
    input  logic               data_en,
    input  logic               first,
    input  logic [WADDR_W-1:0] word_addr,
    input  logic               code_en,
    input  logic [1:0]         code_slot,
    input  logic [BUS_W-1:0]   st_data,
    output logic [LOC_W-1:0]   par_q,
    output logic [LOC_W-1:0]   npar_q,
    output logic [LOC_W-1:0]   par_nxt,
    output logic [LOC_W-1:0]   npar_nxt
);

    // Bus lanes whose index has bit k set
    function automatic logic [BUS_W-1:0] lane_mask(input int k);
        logic [BUS_W-1:0] m;
        for (int i = 0; i < BUS_W; i++)
            m[i] = ((i >> k) & 1) == 1;
        return m;
    endfunction

    logic [BUS_W-1:0] dmask;
    logic             odd;
    logic [BIT_W-1:0] bit_sum;
    logic [LOC_W-1:0] contrib;
    logic [LOC_W-1:0] ncontrib;
    logic [LOC_W-1:0] code_val;
    logic             code_to_n;

    assign dmask = wide ? st_data : {8'h00, st_data[7:0]};
    assign odd   = ^dmask;

    // One XOR tree per bit-offset position
    for (genvar k = 0; k < BIT_W; k++) begin : g_bitpos
        localparam logic [BUS_W-1:0] LM = lane_mask(k);
        assign bit_sum[k] = ^(dmask & LM);
    end

    assign contrib  = {odd ? word_addr : {WADDR_W{1'b0}}, bit_sum};
    assign ncontrib = contrib ^ {LOC_W{odd}};

    // Place a code word into its byte or halfword lane
    always_comb begin
        if (wide) begin
            code_val  = st_data;
            code_to_n = code_slot[0];
        end else begin
            code_val  = code_slot[0] ? {st_data[7:0], 8'h00} : {8'h00, st_data[7:0]};
            code_to_n = code_slot[1];
        end
    end

    // Next accumulator values
    always_comb begin
        par_nxt  = par_q;
        npar_nxt = npar_q;
        if (data_en) begin
            if (first) begin
                par_nxt  = contrib;
                npar_nxt = ncontrib;
            end else begin
                par_nxt  = par_q ^ contrib;
                npar_nxt = npar_q ^ ncontrib;
            end
        end else if (code_en) begin
            if (code_to_n)
                npar_nxt = npar_q ^ code_val;
            else
                par_nxt = par_q ^ code_val;
        end
    end

    // Accumulator registers
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            par_q  <= '0;
            npar_q <= '0;
        end else begin
            par_q  <= par_nxt;
            npar_q <= npar_nxt;
        end
    end

endmodule

// File: rtl/hecc_page_engine.sv
// Page Hamming ECC engine top: ties the register port, page counter and
// accumulators together and holds the status flags. Assumes software
// sets the mode only while the counter sits at a page boundary.
module hecc_page_engine
    import hecc_pkg::*;
#(
    parameter int BASE_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        st_valid,
    input  logic        st_read,
    input  logic [15:0] st_data
);

    logic [1:0]         size_sel;
    logic               wide;
    logic               clr;
    logic [WADDR_W-1:0] word_addr;
    phase_e             phase;
    logic [1:0]         code_slot;
    logic               first_word;
    logic               code_last;
    logic [LOC_W-1:0]   par_q;
    logic [LOC_W-1:0]   npar_q;
    logic [LOC_W-1:0]   par_nxt;
    logic [LOC_W-1:0]   npar_nxt;
    stat_t              stat_q;
    logic               data_en;
    logic               code_en;
    logic               first_acc;
    logic               last_acc;
    logic               wr_tail_acc;

    assign data_en     = st_valid && (phase == PH_DATA);
    assign code_en     = st_valid && st_read && (phase == PH_CODE);
    assign first_acc   = st_valid && first_word;
    assign last_acc    = code_en && code_last;
    assign wr_tail_acc = st_valid && !st_read && (phase != PH_DATA);

    hecc_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .stat      (stat_q),
        .par       (par_q),
        .npar      (npar_q),
        .reg_rdata (reg_rdata),
        .size_sel  (size_sel),
        .wide      (wide),
        .clr       (clr)
    );

    hecc_page_seq #(.BASE_BYTES(BASE_BYTES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .size_sel   (size_sel),
        .wide       (wide),
        .st_valid   (st_valid),
        .word_addr  (word_addr),
        .phase      (phase),
        .code_slot  (code_slot),
        .first_word (first_word),
        .code_last  (code_last)
    );

    hecc_parity_acc u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .wide      (wide),
        .data_en   (data_en),
        .first     (first_word),
        .word_addr (word_addr),
        .code_en   (code_en),
        .code_slot (code_slot),
        .st_data   (st_data),
        .par_q     (par_q),
        .npar_q    (npar_q),
        .par_nxt   (par_nxt),
        .npar_nxt  (npar_nxt)
    );

    // Status: cleared by a new page, loaded when the last code word lands
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            stat_q <= '0;
        else if (first_acc)
            stat_q <= '0;
        else if (last_acc)
            stat_q <= classify(par_nxt, npar_nxt);
    end

endmodule

// File: rtl/hecc_page_engine_chk.sv
// Property checker for the page ECC engine, bound to every instance of the top.
module hecc_page_engine_chk
    import hecc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [2:0]  stat,
    input logic [15:0] par,
    input logic [15:0] npar,
    input logic        first_acc,
    input logic        last_acc,
    input logic        wr_tail_acc
);

    logic clr_req;
    assign clr_req = reg_we && (reg_addr == OFS_CTRL) && reg_wdata[0];

    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> (stat == 3'b0 && par == 16'h0 && npar == 16'h0)); // R1
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) clr_req |=> (stat == 3'b0 && par == 16'h0 && npar == 16'h0)); // R4
    AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n) (stat[1] || stat[2]) |-> stat[0]); // R5
    AST_DATA_LOC: assert property (@(posedge clk) disable iff (!rst_n) (stat == 3'b001) |-> ((par ^ npar) == 16'hFFFF)); // R6
    AST_CODE_ONEBIT: assert property (@(posedge clk) disable iff (!rst_n) stat[2] |-> ($countones({npar, par}) == 1)); // R7
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(stat[1] && stat[2])); // R8
    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!clr_req && !first_acc && !last_acc) |=> $stable(stat)); // R10
    AST_WR_TAIL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (wr_tail_acc && !clr_req) |=> ($stable(par) && $stable(npar))); // R11

endmodule

bind hecc_page_engine hecc_page_engine_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .stat        (stat_q),
    .par         (par_q),
    .npar        (npar_q),
    .first_acc   (first_acc),
    .last_acc    (last_acc),
    .wr_tail_acc (wr_tail_acc)
);

// File: tb/hecc_page_engine_tb_top.sv
// Scoreboard bench: the driver streams pages and queues expected register
// values; the monitor pops each item and compares it with the register reads.
module hecc_page_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 128;
    localparam int WDOG       = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        st_valid = 1'b0;
    logic        st_read = 1'b0;
    logic [15:0] st_data = 16'h0;

    hecc_page_engine #(.BASE_BYTES(BASE)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .st_valid  (st_valid),
        .st_read   (st_read),
        .st_data   (st_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        string       tag;
        logic [2:0]  stat;
        logic [15:0] par;
        logic [15:0] npar;
        bit          chk_par;
    } exp_t;

    exp_t        exp_q[$];
    int          pending = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    logic [15:0] page_mem [0:1023];
    logic [31:0] seed = 32'h1234_5678;

    task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // Monitor: pops expected items and compares them with register reads
    initial begin
        forever begin
            exp_t e;
            logic [31:0] s, p, n;
            wait (pending > 0);
            @(negedge clk);
            e = exp_q.pop_front();
            reg_addr = 3'd2; #1; s = reg_rdata;
            reg_addr = 3'd3; #1; p = reg_rdata;
            reg_addr = 3'd4; #1; n = reg_rdata;
            check(e.tag, "status", s, {29'h0, e.stat});
            if (e.chk_par) begin
                check(e.tag, "parity", p, {16'h0, e.par});
                check(e.tag, "inv parity", n, {16'h0, e.npar});
            end
            pending--;
        end
    end

    task automatic expect_regs(input string tag, input logic [2:0] st, input logic [15:0] p,
                               input logic [15:0] n, input bit cp);
        exp_t e;
        repeat (2) @(negedge clk);
        e.tag = tag; e.stat = st; e.par = p; e.npar = n; e.chk_par = cp;
        exp_q.push_back(e);
        pending++;
        wait (pending == 0);
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_mode(input int sel, input bit wide);
        reg_write(3'd1, {27'h0, wide, 2'b00, sel[1:0]});
    endtask

    task automatic do_clear();
        reg_write(3'd0, 32'h1);
    endtask

    function automatic logic [15:0] next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[23:8];
    endfunction

    task automatic fill_rand(input int n);
        for (int i = 0; i < n; i++) page_mem[i] = next_rand();
    endtask

    // Reference code: XOR of {word,bit} and its complement over set bits
    function automatic logic [31:0] model_code(input int n, input bit wide);
        logic [15:0] p, q, v;
        p = 16'h0; q = 16'h0;
        for (int w = 0; w < n; w++)
            for (int b = 0; b < (wide ? 16 : 8); b++)
                if (page_mem[w][b]) begin
                    v = {w[11:0], b[3:0]};
                    p ^= v;
                    q ^= ~v;
                end
        return {q, p};
    endfunction

    function automatic int data_words(input int sel, input bit wide);
        return (BASE << sel) >> (wide ? 1 : 0);
    endfunction

    // Driver: streams one whole page with code and junk spare words
    task automatic send_page(input bit rd, input int sel, input bit wide, input logic [31:0] code,
                             input bit tchk, input logic [2:0] texp);
        int dw, tot, cw, slot;
        dw = data_words(sel, wide);
        tot = dw + dw / 32;
        cw = wide ? 2 : 4;
        reg_addr = 3'd2;
        for (int i = 0; i < tot; i++) begin
            @(negedge clk);
            if (tchk && i == dw + cw)
                check("R10", "status after last code word", reg_rdata, {29'h0, texp});
            if (tchk && i == dw + cw - 1)
                check("R10", "status before last code word", reg_rdata, 32'h0);
            st_valid = 1'b1;
            st_read  = rd;
            if (i < dw) begin
                st_data = page_mem[i];
            end else if (i < dw + cw) begin
                slot = i - dw;
                if (wide) st_data = slot == 0 ? code[15:0] : code[31:16];
                else      st_data = {next_rand()[7:0], code[8*slot +: 8]};
            end else begin
                st_data = next_rand();
            end
        end
        @(negedge clk);
        st_valid = 1'b0;
        if (tchk && tot == dw + cw)
            check("R10", "status after last code word", reg_rdata, {29'h0, texp});
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_PERIOD * WDOG);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] code, code2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        reg_addr = 3'd1; #1;
        check("R1", "mode after reset", reg_rdata, 32'h0);
        expect_regs("R1", 3'b000, 16'h0, 16'h0, 1'b1);

        // R2 R9 R11: byte-mode write page, junk upper bytes and spare
        set_mode(0, 1'b0);
        fill_rand(data_words(0, 1'b0));
        code = model_code(data_words(0, 1'b0), 1'b0);
        send_page(1'b0, 0, 1'b0, 32'hA5A5_5A5A, 1'b0, 3'b000);
        expect_regs("R2 R11 R9", 3'b000, code[15:0], code[31:16], 1'b1);

        // R5: clean read gives a zero syndrome
        send_page(1'b1, 0, 1'b0, code, 1'b1, 3'b000);
        expect_regs("R5", 3'b000, 16'h0, 16'h0, 1'b1);

        // R6 R10: single data bit error at byte 37, bit 5
        page_mem[37][5] = ~page_mem[37][5];
        send_page(1'b1, 0, 1'b0, code, 1'b1, 3'b001);
        expect_regs("R6", 3'b001, 16'h0255, 16'hFDAA, 1'b1);
        repeat (20) @(negedge clk);
        expect_regs("R10 hold", 3'b001, 16'h0255, 16'hFDAA, 1'b1);

        // R10: first word of the next page clears the status
        reg_addr = 3'd2;
        @(negedge clk);
        st_valid = 1'b1; st_read = 1'b1; st_data = 16'h00FF;
        @(negedge clk);
        st_valid = 1'b0;
        check("R10", "status after next page start", reg_rdata, 32'h0);
        do_clear();
        page_mem[37][5] = ~page_mem[37][5];

        // R7: one flipped code bit (bit 20 = inverted-parity bit 4)
        send_page(1'b1, 0, 1'b0, code ^ 32'h0010_0000, 1'b1, 3'b101);
        expect_regs("R7", 3'b101, 16'h0000, 16'h0010, 1'b1);

        // R8: two data bit errors
        page_mem[3][0] = ~page_mem[3][0];
        page_mem[90][6] = ~page_mem[90][6];
        send_page(1'b1, 0, 1'b0, code, 1'b1, 3'b011);
        expect_regs("R8", 3'b011, 16'h0, 16'h0, 1'b0);

        // R8: erased page, all data and code bytes 8'hFF
        for (int i = 0; i < 128; i++) page_mem[i] = 16'hFFFF;
        send_page(1'b1, 0, 1'b0, 32'hFFFF_FFFF, 1'b1, 3'b011);
        expect_regs("R8 erased", 3'b011, 16'hFFFF, 16'hFFFF, 1'b1);

        // R4: restart zeroes status and accumulators
        do_clear();
        expect_regs("R4", 3'b000, 16'h0, 16'h0, 1'b1);

        // R9 R3: halfword mode, size 1
        set_mode(1, 1'b1);
        reg_addr = 3'd1; #1;
        check("R9", "mode readback", reg_rdata, 32'h11);
        fill_rand(data_words(1, 1'b1));
        code = model_code(data_words(1, 1'b1), 1'b1);
        send_page(1'b0, 1, 1'b1, 32'h0, 1'b0, 3'b000);
        expect_regs("R9 R3 write", 3'b000, code[15:0], code[31:16], 1'b1);
        page_mem[100][13] = ~page_mem[100][13];
        send_page(1'b1, 1, 1'b1, code, 1'b1, 3'b001);
        expect_regs("R9 R6 halfword", 3'b001, 16'h064D, 16'hF9B2, 1'b1);

        // R4: partial junk page, restart, then a clean page
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            st_valid = 1'b1; st_read = 1'b0; st_data = next_rand();
        end
        @(negedge clk);
        st_valid = 1'b0;
        do_clear();
        fill_rand(data_words(1, 1'b1));
        code = model_code(data_words(1, 1'b1), 1'b1);
        send_page(1'b0, 1, 1'b1, 32'h0, 1'b0, 3'b000);
        expect_regs("R4 restart", 3'b000, code[15:0], code[31:16], 1'b1);

        // R3: size 2 byte mode, two pages back to back without restart
        set_mode(2, 1'b0);
        fill_rand(data_words(2, 1'b0));
        send_page(1'b0, 2, 1'b0, 32'h0, 1'b0, 3'b000);
        fill_rand(data_words(2, 1'b0));
        code2 = model_code(data_words(2, 1'b0), 1'b0);
        send_page(1'b0, 2, 1'b0, 32'h0, 1'b0, 3'b000);
        expect_regs("R3 wrap", 3'b000, code2[15:0], code2[31:16], 1'b1);

        // R3: size 3 halfword mode write then clean read
        set_mode(3, 1'b1);
        fill_rand(data_words(3, 1'b1));
        code = model_code(data_words(3, 1'b1), 1'b1);
        send_page(1'b0, 3, 1'b1, 32'h0, 1'b0, 3'b000);
        expect_regs("R3 size3", 3'b000, code[15:0], code[31:16], 1'b1);
        send_page(1'b1, 3, 1'b1, code, 1'b1, 3'b000);
        expect_regs("R3 R5 size3 read", 3'b000, 16'h0, 16'h0, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule